// File: doc/BRIEF.md
# Texture Memory Run Loader

This block moves a linear run of texel data from a 64-bit system-memory read port into a 4 KB on-chip texture memory that is organised as 64-bit words. Each command names a destination word in texture memory, a source word in system memory, the index of the last texel in the run, a two-bit texel size code and an unsigned 1.11 fixed-point line-advance step. The block checks the command against both memory limits before it moves any data. It then fetches the run one 64-bit word at a time and writes each word into texture memory.

The line-advance step sets the length of a texture row. It is the reciprocal of the row length in words, so a row holds ceil(2048 / step) words. Rows alternate, starting with a straight row. On every odd row the block rearranges data so that a later sampler can fetch two neighbouring rows without bank conflicts. For texels narrower than 32 bits it swaps the two 32-bit halves of each word. For 32-bit texels it trades neighbouring 64-bit words inside each 128-bit pair. A step of zero turns the rearrangement off.

One command is handled at a time. The block lowers its command-ready output while a run is in progress. It signals a completed run with a one-cycle done pulse and a refused command with a one-cycle error pulse.

Top module: `tex_block_loader`

## Requirements
- R1: The run length in bytes is ((last_texel + 1) << size_code) >> 1, and the number of 64-bit words moved is that byte count rounded up to a whole word (an odd 7-byte run still moves one word).
- R2: On straight rows, word i of the run is written unchanged to texture word dst + i.
- R3: With a step of zero, every word of the run is written straight, with no half swap and no address change.
- R4: With a nonzero step, each row holds ceil(2048 / step) words. Row 0 is straight and rows then alternate. A final partial row holds the words that remain.
- R5: On odd rows with size codes 0, 1 and 2, the word keeps its address, and data bits [31:0] and [63:32] trade places.
- R6: On odd rows with size code 3 (32-bit texels), the data is unchanged and is written to the destination word address XOR 1.
- R7: A command whose run is zero bytes, or whose dst*8 + bytes exceeds 4096, is refused. err pulses for one cycle in the cycle after the command is taken, and no read or write follows.
- R8: A command whose src*8 + bytes exceeds the source memory size (SRC_BYTES, 1 MB by default) is refused in the same way as in R7.
- R9: Reads go out in order at src + i with one request outstanding. Each word is written in the cycle after its read data is presented.
- R10: Exactly one done pulse follows each accepted run, one cycle after the cycle in which the final word write is presented.
- R11: cmd_ready is low from the cycle after a command is accepted until the run ends. Commands presented in that time are ignored.
- R12: After reset, cmd_ready is high and rd_req_valid, tm_we, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_dst | input | 9 | Destination texture word address |
| cmd_src | input | 17 | Source system-memory word address |
| cmd_last_texel | input | 12 | Index of the last texel in the run |
| cmd_size | input | 2 | Texel size code: 0=4b, 1=8b, 2=16b, 3=32b |
| cmd_step | input | 12 | Line-advance step, unsigned 1.11 |
| rd_req_valid | output | 1 | Read request |
| rd_req_ready | input | 1 | Read request taken |
| rd_req_addr | output | 17 | Source word address being read |
| rd_data_valid | input | 1 | Read data present |
| rd_data | input | 64 | Read data word |
| tm_we | output | 1 | Texture memory write strobe |
| tm_addr | output | 9 | Texture memory word address |
| tm_wdata | output | 64 | Texture memory write data |
| done | output | 1 | One-cycle pulse when a run is complete |
| err | output | 1 | One-cycle pulse when a command is refused |

## Verification
A texture write is due one cycle after the read beat that carries its data. done is due one cycle after the final write, and err is due one cycle after a refused command is taken. The bench holds a queue of expected writes, built from the formulas above, and checks the outputs on every falling edge, so each result is sampled in the cycle it is due and never at a clock edge. It counts cycles to confirm that done falls exactly one cycle after the last write. A stalling read responder with varying latency shows that the write timing follows the data beats and not a fixed schedule.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int EDGE_W = 12;
  localparam int STEP_W = 12;
  localparam int BYTE_W = EDGE_W + 4;
  localparam int WCNT_W = BYTE_W - 2;

  typedef logic [BYTE_W-1:0] tl_bytes_t;
  typedef logic [WCNT_W-1:0] tl_words_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_FIN} tl_state_e;

  // bytes in a run of (last+1) texels at 2^size half-bytes each
  function automatic tl_bytes_t tl_run_bytes(input logic [EDGE_W-1:0] last_tx,
                                             input logic [1:0] sz);
    logic [BYTE_W:0] wide;
    wide = ((BYTE_W+1)'(last_tx) + (BYTE_W+1)'(1)) << sz;
    return wide[BYTE_W:1];
  endfunction

  // whole 64-bit words needed to hold a byte run
  function automatic tl_words_t tl_run_words(input tl_bytes_t b);
    logic [BYTE_W:0] s;
    s = (BYTE_W+1)'(b) + (BYTE_W+1)'(7);
    return s[BYTE_W:3];
  endfunction
endpackage

// File: rtl/tl_cmd_check.sv
module tl_cmd_check import tl_pkg::*; #(
  parameter int TMEM_BYTES = 4096,
  parameter int SRC_BYTES  = 1 << 20,
  parameter int TM_AW      = 9,
  parameter int SRC_AW     = 17
)(
  input  logic [TM_AW-1:0]  dst,
  input  logic [SRC_AW-1:0] src,
  input  logic [EDGE_W-1:0] last_tx,
  input  logic [1:0]        sz,
  output tl_words_t         words,
  output logic              fits
);
  localparam int AW_MAX = (SRC_AW > TM_AW) ? SRC_AW : TM_AW;
  localparam int CW = ((AW_MAX + 3 > BYTE_W) ? AW_MAX + 3 : BYTE_W) + 1;

  tl_bytes_t       bytes;
  logic [CW-1:0]   tm_end;
  logic [CW-1:0]   src_end;

  always_comb begin
    bytes   = tl_run_bytes(last_tx, sz);
    words   = tl_run_words(bytes);
    tm_end  = CW'({dst, 3'b000}) + CW'(bytes);
    src_end = CW'({src, 3'b000}) + CW'(bytes);
    fits    = (bytes != '0) && (tm_end <= CW'(TMEM_BYTES)) && (src_end <= CW'(SRC_BYTES));
  end

  // an accepted run is never empty and never larger than the texture memory (R7)
  always_comb begin
    if (fits) begin
      assert_words_fit_R7: assert (words != '0 && 32'(words) <= TMEM_BYTES / 8);
    end
  end
endmodule

// File: rtl/tl_row_tracker.sv
module tl_row_tracker #(
  parameter int STEP_W = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic              odd_row,
  output logic              row_wrap
);
  localparam int ONE = 1 << (STEP_W - 1);

  logic [STEP_W-1:0] acc_q;
  logic              odd_q;
  logic [STEP_W:0]   acc_next;
  logic              interleave_on;

  assign interleave_on = (step != '0);
  assign acc_next      = {1'b0, acc_q} + {1'b0, step};
  assign row_wrap      = adv && interleave_on && (acc_next >= (STEP_W+1)'(ONE));
  assign odd_row       = odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      odd_q <= 1'b0;
    end else if (clear) begin
      acc_q <= '0;
      odd_q <= 1'b0;
    end else if (row_wrap) begin
      acc_q <= '0;
      odd_q <= ~odd_q;
    end else if (adv && interleave_on) begin
      acc_q <= acc_next[STEP_W-1:0];
    end
  end

  assert_acc_below_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < STEP_W'(ONE));

  assert_wrap_flips_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    row_wrap |=> (odd_q != $past(odd_q)));

  assert_flat_when_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!interleave_on && !clear) |=> $stable(odd_q));
endmodule

// File: rtl/tex_block_loader.sv
module tex_block_loader import tl_pkg::*; #(
  parameter int TMEM_BYTES = 4096,
  parameter int SRC_BYTES  = 1 << 20,
  parameter int DW         = 64
)(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cmd_valid,
  output logic                                cmd_ready,
  input  logic [$clog2(TMEM_BYTES/8)-1:0]     cmd_dst,
  input  logic [$clog2(SRC_BYTES/8)-1:0]      cmd_src,
  input  logic [EDGE_W-1:0]                   cmd_last_texel,
  input  logic [1:0]                          cmd_size,
  input  logic [STEP_W-1:0]                   cmd_step,
  output logic                                rd_req_valid,
  input  logic                                rd_req_ready,
  output logic [$clog2(SRC_BYTES/8)-1:0]      rd_req_addr,
  input  logic                                rd_data_valid,
  input  logic [DW-1:0]                       rd_data,
  output logic                                tm_we,
  output logic [$clog2(TMEM_BYTES/8)-1:0]     tm_addr,
  output logic [DW-1:0]                       tm_wdata,
  output logic                                done,
  output logic                                err
);
  localparam int TM_AW  = $clog2(TMEM_BYTES / 8);
  localparam int SRC_AW = $clog2(SRC_BYTES / 8);
  localparam int HALF   = DW / 2;

  tl_state_e          state;
  logic [TM_AW-1:0]   dst_q;
  logic [SRC_AW-1:0]  src_q;
  logic [1:0]         size_q;
  logic [STEP_W-1:0]  step_q;
  tl_words_t          words_q;
  tl_words_t          idx_q;
  logic               tm_we_q;
  logic [TM_AW-1:0]   tm_addr_q;
  logic [DW-1:0]      tm_wdata_q;
  logic               done_q;
  logic               err_q;

  tl_words_t          chk_words;
  logic               chk_fits;
  logic               odd_row;
  logic               row_wrap;

  // named internal events
  logic               cmd_fire, cmd_take, cmd_drop, beat, last_beat, wide_texel;
  logic [TM_AW-1:0]   word_abs, map_addr;
  logic [DW-1:0]      map_data;

  tl_cmd_check #(
    .TMEM_BYTES(TMEM_BYTES), .SRC_BYTES(SRC_BYTES), .TM_AW(TM_AW), .SRC_AW(SRC_AW)
  ) u_check (
    .dst(cmd_dst), .src(cmd_src), .last_tx(cmd_last_texel), .sz(cmd_size),
    .words(chk_words), .fits(chk_fits)
  );

  assign cmd_fire   = (state == ST_IDLE) && cmd_valid;
  assign cmd_take   = cmd_fire && chk_fits;
  assign cmd_drop   = cmd_fire && !chk_fits;
  assign beat       = (state == ST_WAIT) && rd_data_valid;
  assign last_beat  = beat && (idx_q == words_q - tl_words_t'(1));
  assign wide_texel = (size_q == 2'd3);

  tl_row_tracker #(.STEP_W(STEP_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .clear(cmd_take), .adv(beat), .step(step_q),
    .odd_row(odd_row), .row_wrap(row_wrap)
  );

  always_comb begin
    word_abs = dst_q + TM_AW'(idx_q);
    map_addr = (odd_row && wide_texel) ? (word_abs ^ TM_AW'(1)) : word_abs;
    map_data = (odd_row && !wide_texel) ? {rd_data[HALF-1:0], rd_data[DW-1:HALF]} : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      dst_q      <= '0;
      src_q      <= '0;
      size_q     <= '0;
      step_q     <= '0;
      words_q    <= '0;
      idx_q      <= '0;
      tm_we_q    <= 1'b0;
      tm_addr_q  <= '0;
      tm_wdata_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      tm_we_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= cmd_drop;
      case (state)
        ST_IDLE: if (cmd_take) begin
          dst_q   <= cmd_dst;
          src_q   <= cmd_src;
          size_q  <= cmd_size;
          step_q  <= cmd_step;
          words_q <= chk_words;
          idx_q   <= '0;
          state   <= ST_REQ;
        end
        ST_REQ: if (rd_req_ready) state <= ST_WAIT;
        ST_WAIT: if (rd_data_valid) begin
          tm_we_q    <= 1'b1;
          tm_addr_q  <= map_addr;
          tm_wdata_q <= map_data;
          idx_q      <= idx_q + tl_words_t'(1);
          state      <= last_beat ? ST_FIN : ST_REQ;
        end
        ST_FIN: begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (state == ST_IDLE);
  assign rd_req_valid = (state == ST_REQ);
  assign rd_req_addr  = src_q + SRC_AW'(idx_q);
  assign tm_we        = tm_we_q;
  assign tm_addr      = tm_addr_q;
  assign tm_wdata     = tm_wdata_q;
  assign done         = done_q;
  assign err          = err_q;

  assert_write_follows_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tm_we |-> $past(rd_data_valid));

  assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(tm_we) && cmd_ready));

  assert_single_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!tm_we && !rd_req_valid && cmd_ready));

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || tm_we) |-> !cmd_ready);
endmodule

// File: tb/tex_block_loader_test.sv
module tex_block_loader_test;
  localparam int SRC_LIMIT = 1 << 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [8:0]  cmd_dst = '0;
  logic [16:0] cmd_src = '0;
  logic [11:0] cmd_last_texel = '0;
  logic [1:0]  cmd_size = '0;
  logic [11:0] cmd_step = '0;
  logic        rd_req_valid;
  logic        rd_req_ready;
  logic [16:0] rd_req_addr;
  logic        rd_data_valid;
  logic [63:0] rd_data;
  logic        tm_we;
  logic [8:0]  tm_addr;
  logic [63:0] tm_wdata;
  logic        done;
  logic        err;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int last_we_cyc = -10;
  int done_hits = 0;
  int stall_mode = 0;

  logic [8:0]  exp_addr[$];
  logic [63:0] exp_data[$];
  string       exp_req[$];

  tex_block_loader #(.TMEM_BYTES(4096), .SRC_BYTES(SRC_LIMIT), .DW(64)) uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] src_word(input int a);
    return {32'hC0DE0000 ^ 32'(a), 32'h00510000 + 32'(a)};
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n && tm_we) begin
      last_we_cyc = cyc;
      if (exp_addr.size() == 0) begin
        chk(1'b0, "R11", tm_addr, 0);
      end else begin
        chk(tm_addr == exp_addr[0], exp_req[0], tm_addr, exp_addr[0]);
        chk(tm_wdata == exp_data[0], exp_req[0], tm_wdata, exp_data[0]);
        void'(exp_addr.pop_front());
        void'(exp_data.pop_front());
        void'(exp_req.pop_front());
      end
    end
    if (rst_n && done) begin
      done_hits++;
      chk(cyc == last_we_cyc + 1, "R10", cyc, last_we_cyc + 1);
      chk(exp_addr.size() == 0, "R10", exp_addr.size(), 0);
    end
  end

  // read responder: one request at a time, optional stalls and latency
  initial begin
    int lat_cnt;
    int pend;
    lat_cnt = 0;
    pend = 0;
    rd_req_ready = 1'b0;
    rd_data_valid = 1'b0;
    rd_data = '0;
    forever begin
      @(negedge clk);
      rd_req_ready = 1'b0;
      rd_data_valid = 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          rd_data_valid = 1'b1;
          rd_data = src_word(pend);
        end
      end else if (rd_req_valid) begin
        if (stall_mode == 0 || (cyc % 3) == 1) begin
          rd_req_ready = 1'b1;
          pend = int'(rd_req_addr);
          lat_cnt = (stall_mode == 0) ? 1 : 1 + (cyc % 2);
        end
      end
    end
  end

  task automatic run_cmd(input int dst, input int src, input int last_tx, input int sz,
                         input int step, input bit poke_busy, input string tag);
    int bytes;
    int words;
    int wpr;
    int guard;
    int hits0;
    bit fits;
    bytes = ((last_tx + 1) << sz) >> 1;
    words = (bytes + 7) / 8;
    fits = (bytes != 0) && (dst * 8 + bytes <= 4096) && (src * 8 + bytes <= SRC_LIMIT);
    wpr = (step == 0) ? 1 << 30 : (2048 + step - 1) / step;
    if (fits) begin
      for (int i = 0; i < words; i++) begin
        bit odd;
        logic [8:0] a;
        logic [63:0] d;
        odd = ((i / wpr) % 2) == 1;
        a = 9'(dst + i);
        d = src_word(src + i);
        if (odd && sz == 3) begin
          a = a ^ 9'd1;
          exp_req.push_back("R6");
        end else if (odd) begin
          d = {d[31:0], d[63:32]};
          exp_req.push_back("R5");
        end else begin
          exp_req.push_back(tag);
        end
        exp_addr.push_back(a);
        exp_data.push_back(d);
      end
    end
    hits0 = done_hits;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_dst = 9'(dst);
    cmd_src = 17'(src);
    cmd_last_texel = 12'(last_tx);
    cmd_size = 2'(sz);
    cmd_step = 12'(step);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!fits) begin
      chk(err == 1'b1, tag, err, 1);
      @(negedge clk);
      chk(err == 1'b0, tag, err, 0);
      repeat (8) @(negedge clk);
      chk(done_hits == hits0, tag, done_hits, hits0);
      chk(cmd_ready == 1'b1, tag, cmd_ready, 1);
    end else begin
      chk(err == 1'b0, "R7", err, 0);
      chk(cmd_ready == 1'b0, "R11", cmd_ready, 0);
      if (poke_busy) begin
        cmd_dst = 9'd0;
        cmd_src = 17'd0;
        cmd_last_texel = 12'd3;
        cmd_size = 2'd2;
        cmd_step = 12'd0;
        for (int k = 0; k < 3; k++) begin
          cmd_valid = 1'b1;
          @(negedge clk);
          chk(cmd_ready == 1'b0, "R11", cmd_ready, 0);
        end
        cmd_valid = 1'b0;
      end
      guard = 0;
      while (done_hits == hits0 && guard < 4000) begin
        @(negedge clk);
        guard++;
      end
      repeat (4) @(negedge clk);
      chk(done_hits == hits0 + 1, "R10", done_hits, hits0 + 1);
      chk(exp_addr.size() == 0, tag, exp_addr.size(), 0);
      chk(cmd_ready == 1'b1, "R11", cmd_ready, 1);
    end
    exp_addr.delete();
    exp_data.delete();
    exp_req.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(cmd_ready == 1'b1, "R12", cmd_ready, 1);
    chk(rd_req_valid == 1'b0, "R12", rd_req_valid, 0);
    chk(tm_we == 1'b0, "R12", tm_we, 0);
    chk(done == 1'b0 && err == 1'b0, "R12", {done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cmd(10, 100, 15, 2, 0, 1'b0, "R3");      // R3: 4 words, all straight
    run_cmd(20, 200, 63, 2, 512, 1'b1, "R4");    // R4: 16 words, rows of 4; R11 poke
    stall_mode = 1;
    run_cmd(40, 300, 79, 1, 683, 1'b0, "R4");    // R4: rows of 3, partial last row
    run_cmd(3, 400, 31, 3, 1024, 1'b0, "R2");    // R6: 32-bit, rows of 2, odd base
    run_cmd(60, 500, 9, 2, 2048, 1'b0, "R2");    // R4: one word per row
    stall_mode = 0;
    run_cmd(70, 600, 14, 0, 0, 1'b0, "R1");      // R1: 7 bytes round up to one word
    run_cmd(90, 700, 20, 1, 0, 1'b0, "R1");      // R1: 21 bytes -> 3 words
    run_cmd(508, 800, 15, 2, 0, 1'b0, "R2");     // R7 boundary: ends exactly at 4096
    run_cmd(510, 800, 15, 2, 0, 1'b0, "R7");     // R7: destination overflow
    run_cmd(0, 0, 0, 0, 0, 1'b0, "R7");          // R7: zero-byte run
    run_cmd(0, 131070, 15, 2, 0, 1'b0, "R8");    // R8: source overflow
    run_cmd(0, 131068, 15, 2, 0, 1'b0, "R9");    // R8 boundary: ends exactly at limit
    run_cmd(100, 1000, 63, 3, 300, 1'b0, "R9");  // R6 with rows of 7 words

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule